// File: doc/BRIEF.md
# Dual-Channel Bus Break Comparator

This block watches the bus cycles a processor issues and raises a break request when a cycle meets a programmed condition. Each of its two channels, A and B, holds five values: a target address, an address mask, a target data word, a data mask and a condition byte. The condition byte selects which bus is watched, whether the channel looks at instruction fetches, data accesses or both, the direction and the access size. Software programs these values through a simple register write port. The block then flags every cycle that qualifies.

The channels either act on their own, or they form an ordered pair in which channel A arms the pair and a later channel B hit completes it. A fetch condition models a break taken before the fetched instruction runs. Two rules apply to fetches. A fetch always counts as a read. A fetch condition whose programmed address is odd can never hit. A companion output tells the processor that a break came from a fetch, so that the instruction in question is not executed.

Top module: `bus_break_cmp`

## Requirements
- R1: After reset every register is zero and brk_req, brk_fetch, match_a and match_b are 0. A channel whose condition type field (bits 1:0) is 0 never hits.
- R2: Address compare: a hit needs (bus_addr XOR address) AND NOT mask to be zero. A mask bit of 1 drops that bit from the compare, and an all-zero mask demands an exact address.
- R3: On a data-access cycle the data word is compared under its own mask in the same way. On a fetch cycle the data word plays no part.
- R4: Condition byte fields. Bits 1:0 give the type: 1 = fetch, 2 = data, 3 = either. Bits 3:2 give the direction: 1 = read, 2 = write, 3 = either. Bits 5:4 give the size: 0 = not compared, 1 = byte, 2 = word, 3 = long, matched against bus_size. Bit 6 gives the bus and must equal bus_sel. Only cycles with bus_valid = 1 are compared.
- R5: A fetch cycle counts as a read whatever bus_write shows. A fetch condition whose direction is write only (2) never hits.
- R6: A fetch cycle never hits a channel whose programmed address has bit 0 set.
- R7: While control bit 3 is 0 (independent mode), brk_req is 1 for one cycle, one clock after any bus cycle that hits either channel.
- R8: While control bit 3 is 1 (ordered mode), a hit on A arms the pair and does not break. A hit on B while the pair is armed raises brk_req one clock later and disarms the pair. If A and B hit on the same cycle while the pair is unarmed, the cycle arms the pair but does not break. Any write to the control register disarms the pair.
- R9: match_a is set one clock after an A hit. match_b is set one clock after a B hit in independent mode, or after a completed pair in ordered mode. Both flags stay set until a write to the flag register puts 0 in bit 0 (for A) or bit 1 (for B). A new hit in the same cycle as the clearing write wins.
- R10: brk_fetch is 1 together with brk_req when the cycle that caused the break was a fetch.
- R11: Register select on reg_sel: 0 to 4 = A address, A address mask, A data, A data mask, A condition. 5 to 9 = the same five for B. 10 = control. 11 = flag clear. A write takes effect for bus cycles from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (see R11) |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_sel | input | 1 | Which bus carries the cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 1 byte, 2 word, 3 long |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| brk_req | output | 1 | Break request pulse |
| brk_fetch | output | 1 | Break was caused by a fetch |
| match_a | output | 1 | Sticky channel A flag |
| match_b | output | 1 | Sticky channel B flag |

## Verification
Exact addresses are applied next to addresses that differ only in bits the mask covers, which separates a masked compare from a plain one. Data cycles with a differing data word are then applied alongside fetches that carry the same word, which shows that the data compare is applied only to data accesses. Fetches with a write bit set or with an odd programmed address, size and bus mismatches, and B-before-A, A-then-B and simultaneous A-and-B orderings in ordered mode each isolate one of the qualifying rules. The flags are then cleared bit by bit, including a clear that falls on the same clock as a new hit.

// File: rtl/bus_break_cmp.sv
module bus_break_cmp #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          bus_valid,
  input  logic          bus_sel,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          brk_req,
  output logic          brk_fetch,
  output logic          match_a,
  output logic          match_b
);
  localparam int NCH = 2;
  localparam logic [3:0] SEL_CTRL = 4'd10;
  localparam logic [3:0] SEL_FLAG = 4'd11;

  logic [AW-1:0] adr [NCH];
  logic [AW-1:0] amk [NCH];
  logic [DW-1:0] dat [NCH];
  logic [DW-1:0] dmk [NCH];
  logic [7:0]    cnd [NCH];
  logic          seq, armed;
  logic [NCH-1:0] hit;
  logic          fire;

  wire eff_wr = bus_write & ~bus_fetch;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      hit[c] = bus_valid
             & (bus_fetch ? cnd[c][0] : cnd[c][1])
             & (eff_wr ? cnd[c][3] : cnd[c][2])
             & ((cnd[c][5:4] == 2'd0) | (cnd[c][5:4] == bus_size))
             & (cnd[c][6] == bus_sel)
             & (((bus_addr ^ adr[c]) & ~amk[c]) == '0)
             & (bus_fetch ? ~adr[c][0] : (((bus_data ^ dat[c]) & ~dmk[c]) == '0));
    end
  end

  assign fire = seq ? (armed & hit[1]) : (|hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        adr[c] <= '0; amk[c] <= '0; dat[c] <= '0; dmk[c] <= '0; cnd[c] <= '0;
      end
      seq <= 1'b0;
    end else if (reg_we) begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_sel == 4'(5*c + 0)) adr[c] <= reg_wdata[AW-1:0];
        if (reg_sel == 4'(5*c + 1)) amk[c] <= reg_wdata[AW-1:0];
        if (reg_sel == 4'(5*c + 2)) dat[c] <= reg_wdata[DW-1:0];
        if (reg_sel == 4'(5*c + 3)) dmk[c] <= reg_wdata[DW-1:0];
        if (reg_sel == 4'(5*c + 4)) cnd[c] <= reg_wdata[7:0];
      end
      if (reg_sel == SEL_CTRL) seq <= reg_wdata[3];
    end
  end

  wire ctrl_wr = reg_we & (reg_sel == SEL_CTRL);
  wire clr_a   = reg_we & (reg_sel == SEL_FLAG) & ~reg_wdata[0];
  wire clr_b   = reg_we & (reg_sel == SEL_FLAG) & ~reg_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; brk_req <= 1'b0; brk_fetch <= 1'b0;
      match_a <= 1'b0; match_b <= 1'b0;
    end else begin
      brk_req   <= fire;
      brk_fetch <= fire & bus_fetch;
      if (ctrl_wr)            armed <= 1'b0;
      else if (seq && fire)   armed <= 1'b0;
      else if (seq && hit[0]) armed <= 1'b1;
      match_a <= hit[0] | (match_a & ~clr_a);
      match_b <= (seq ? fire : hit[1]) | (match_b & ~clr_b);
    end
  end
endmodule

module bus_break_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [3:0] reg_sel,
  input logic [1:0] reg_wlo,
  input logic       bus_valid,
  input logic       bus_fetch,
  input logic       brk_req,
  input logic       brk_fetch,
  input logic       match_a,
  input logic       match_b,
  input logic       seq,
  input logic       armed
);
  p_fetch_with_brk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fetch |-> brk_req);
  p_fetch_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fetch |-> $past(bus_fetch));
  p_brk_after_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid));
  p_seq_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq)) |-> $past(armed));
  p_seq_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq)) |-> !armed);
  p_sticky_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && !(reg_we && reg_sel == 4'd11 && !reg_wlo[0])) |=> match_a);
  p_sticky_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && !(reg_we && reg_sel == 4'd11 && !reg_wlo[1])) |=> match_b);
endmodule

bind bus_break_cmp bus_break_cmp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wlo(reg_wdata[1:0]), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
  .brk_req(brk_req), .brk_fetch(brk_fetch), .match_a(match_a),
  .match_b(match_b), .seq(seq), .armed(armed)
);

// File: tb/bus_break_cmp_tb.sv
`timescale 1ns/1ps
module bus_break_cmp_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [3:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic bus_valid = 0, bus_sel = 0, bus_fetch = 0, bus_write = 0;
  logic [1:0] bus_size = 0; logic [31:0] bus_addr = 0, bus_data = 0;
  logic brk_req, brk_fetch, match_a, match_b;

  always #2 clk = ~clk;

  bus_break_cmp dut_i (.*);

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int unsigned regs [12];
  bit m_armed, e_brk, e_bf, e_fa, e_fb;

  function automatic bit ref_hit(int ch);
    int unsigned cond = regs[ch*5+4];
    int unsigned ty = cond & 3, dr = (cond >> 2) & 3, sz = (cond >> 4) & 3;
    bit wr = bus_fetch ? 1'b0 : bus_write;
    if (!bus_valid || ty == 0) return 0;
    if (bus_fetch && (ty & 1) == 0) return 0;
    if (!bus_fetch && (ty & 2) == 0) return 0;
    if (wr && (dr & 2) == 0) return 0;
    if (!wr && (dr & 1) == 0) return 0;
    if (sz != 0 && sz != bus_size) return 0;
    if (((cond >> 6) & 1) != bus_sel) return 0;
    if (((bus_addr ^ regs[ch*5]) & ~regs[ch*5+1]) != 0) return 0;
    if (bus_fetch) return (regs[ch*5] & 1) == 0;
    return ((bus_data ^ regs[ch*5+2]) & ~regs[ch*5+3]) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (regs[i]) regs[i] = 0;
      m_armed = 0; e_brk = 0; e_bf = 0; e_fa = 0; e_fb = 0;
    end else begin
      bit ha, hb, sq, f;
      ha = ref_hit(0); hb = ref_hit(1);
      sq = (regs[10] >> 3) & 1;
      f = sq ? (m_armed && hb) : (ha || hb);
      e_brk = f; e_bf = f && bus_fetch;
      if (reg_we && reg_sel == 11) begin
        if (!reg_wdata[0]) e_fa = 0;
        if (!reg_wdata[1]) e_fb = 0;
      end
      if (ha) e_fa = 1;
      if (sq ? f : hb) e_fb = 1;
      if (reg_we && reg_sel == 10) m_armed = 0;
      else if (sq && f) m_armed = 0;
      else if (sq && ha) m_armed = 1;
      if (reg_we && reg_sel < 12) regs[reg_sel] = reg_wdata;
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("brk_req", brk_req, e_brk);
    chk("brk_fetch", brk_fetch, e_bf);
    chk("match_a", match_a, e_fa);
    chk("match_b", match_b, e_fb);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(int sel, int unsigned v);
    @(negedge clk);
    bus_valid = 0; reg_we = 1; reg_sel = 4'(sel); reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic cyc(bit f, bit w, int sz, bit bs, int unsigned a, int unsigned d);
    @(negedge clk);
    reg_we = 0; bus_valid = 1; bus_fetch = f; bus_write = w;
    bus_size = 2'(sz); bus_sel = bs; bus_addr = a; bus_data = d;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); bus_valid = 0; reg_we = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset brk", brk_req, 0); chk("reset flags", {match_a, match_b}, 0);
    cyc(0, 0, 2, 0, 0, 0);           // all-zero regs: disabled
    idle(1);
    chk("R1 disabled", brk_req | match_a, 0);

    cur_req = "R2";
    wr(0, 32'h1000); wr(4, 32'h06);  // A: data read any size bus0
    cyc(0, 0, 3, 0, 32'h1000, 0);
    chk("R2 exact brk", brk_req, 1);
    cyc(0, 0, 3, 0, 32'h1004, 0);
    chk("R2 miss", brk_req, 0);
    wr(1, 32'h0000000F);
    cyc(0, 0, 3, 0, 32'h100C, 0);
    cyc(0, 0, 3, 0, 32'h1010, 0);

    cur_req = "R3";
    wr(1, 0); wr(2, 32'hA5A5_0000); wr(3, 32'h0000_FFFF);
    cyc(0, 0, 3, 0, 32'h1000, 32'hA5A5_1234);
    cyc(0, 0, 3, 0, 32'h1000, 32'hA5A4_0000);
    wr(4, 32'h05);                   // fetch read: data ignored
    cyc(1, 0, 2, 0, 32'h1000, 32'hFFFF_FFFF);
    chk("R3 fetch ignores data", brk_req, 1);

    cur_req = "R4";
    wr(4, 32'h26);                   // data read word
    cyc(0, 0, 1, 0, 32'h1000, 32'hA5A5_0000);
    cyc(0, 0, 2, 0, 32'h1000, 32'hA5A5_0000);
    cyc(0, 1, 2, 0, 32'h1000, 32'hA5A5_0000);
    cyc(0, 0, 2, 1, 32'h1000, 32'hA5A5_0000);
    wr(4, 32'h7A);                   // data write long bus1
    cyc(0, 1, 3, 1, 32'h1000, 32'hA5A5_0000);
    cyc(1, 1, 3, 1, 32'h1000, 32'hA5A5_0000);

    cur_req = "R5";
    wr(4, 32'h29);                   // fetch write word
    cyc(1, 1, 2, 0, 32'h1000, 0);
    cyc(1, 0, 2, 0, 32'h1000, 0);
    chk("R5 fetch-write never", brk_req, 0);
    wr(4, 32'h0D);                   // fetch either dir
    cyc(1, 1, 2, 0, 32'h1000, 0);

    cur_req = "R6";
    wr(0, 32'h1001); wr(4, 32'h05);
    cyc(1, 0, 2, 0, 32'h1001, 0);
    chk("R6 odd fetch", brk_req, 0);
    wr(4, 32'h06);
    cyc(0, 0, 1, 0, 32'h1001, 32'hA5A5_0000);

    cur_req = "R9";
    wr(11, 32'h2);                   // clear A only
    idle(1);
    chk("R9 A cleared", match_a, 0);
    wr(11, 32'h0);

    cur_req = "R7";
    wr(0, 32'h2000); wr(2, 0); wr(3, 32'hFFFFFFFF);
    wr(5, 32'h3000); wr(7, 0); wr(8, 32'hFFFFFFFF); wr(9, 32'h0F);
    cyc(0, 0, 2, 0, 32'h3000, 0);
    chk("R7 B alone", brk_req, 1);
    cyc(0, 0, 2, 0, 32'h2000, 0);
    cyc(1, 0, 2, 0, 32'h3000, 0);
    chk("R10 fetch break", brk_fetch, 1);
    wr(5, 32'h2000);
    cyc(0, 0, 2, 0, 32'h2000, 0);

    cur_req = "R8";
    wr(5, 32'h3000); wr(10, 32'h8); wr(11, 0);
    cyc(0, 0, 2, 0, 32'h3000, 0);
    chk("R8 B before A", brk_req, 0);
    cyc(0, 0, 2, 0, 32'h2000, 0);
    chk("R8 A alone", brk_req, 0);
    idle(2);
    cyc(1, 0, 2, 0, 32'h3000, 0);
    chk("R8 A then B", brk_req, 1);
    cyc(0, 0, 2, 0, 32'h3000, 0);
    chk("R8 disarmed", brk_req, 0);
    cyc(0, 0, 2, 0, 32'h2000, 0);
    wr(10, 32'h8);
    cyc(0, 0, 2, 0, 32'h3000, 0);
    chk("R8 ctrl write disarms", brk_req, 0);
    wr(5, 32'h2000);
    cyc(0, 0, 2, 0, 32'h2000, 0);
    chk("R8 simultaneous", brk_req, 0);
    cyc(0, 0, 2, 0, 32'h2000, 0);
    chk("R8 armed by simultaneous", brk_req, 1);

    cur_req = "R9";
    @(negedge clk);
    reg_we = 1; reg_sel = 11; reg_wdata = 0;
    bus_valid = 1; bus_fetch = 0; bus_write = 0; bus_size = 2;
    bus_sel = 0; bus_addr = 32'h2000;
    @(negedge clk); reg_we = 0; bus_valid = 0;
    chk("R9 set wins", match_a, 1);
    wr(11, 0);
    idle(1);
    chk("R9 both cleared", {match_a, match_b}, 0);

    cur_req = "R11";
    wr(10, 0); wr(9, 0);
    cyc(0, 0, 2, 0, 32'h2000, 0);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule